// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block models the front end of a single-clock synchronous burst SRAM. On every rising edge it takes an address, two address strobes, a burst-advance input, three chip enables and a set of write controls. It classifies the cycle as deselect, begin-burst, continue-burst or suspend-burst. Write cycles put the selected byte lanes into an internal array. Read cycles return the addressed word through two register stages, so read data reaches the output port one clock after the edge that follows the command.

There are two address strobes. The processor-side strobe always starts a read, and it is ignored while the primary chip enable is inactive. The controller-side strobe starts a read or a write, depending on the write controls. The three chip enables are examined only on cycles that carry a strobe, and the selection state they set persists until the next strobe cycle. Between strobes, the advance input either steps through a four-word burst in linear or interleaved order, or holds the current address. A retention input puts the block into a low-power hold in which commands are ignored and the array keeps its contents.

The model uses separate data-in, data-out and output-drive-enable ports instead of a bidirectional data pin.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A read command sampled at rising edge k is captured in the array read register at edge k and in the output register at edge k+1. Its data is on `dout` from edge k+1 until edge k+2.
- R2: When `wr_all_n` is low on a write-capable cycle, all four byte lanes are written, whatever `byte_wr_n` and `lane_wr_n` are.
- R3: With `wr_all_n` high and `byte_wr_n` low, lane i (data bits 8i+7 down to 8i) is written only when `lane_wr_n[i]` is low. If no `lane_wr_n` bit is low, or if `byte_wr_n` is high, the cycle is a read.
- R4: A processor strobe (`strobe_proc_n` low) together with `ce_n` low begins a burst that is always a read, even when the write controls request a write. When `ce_n` is high, the processor strobe is ignored, and the cycle acts as a cycle with no strobe unless the controller strobe is also low.
- R5: A controller strobe (`strobe_ctrl_n` low) without an effective processor strobe begins a burst at `addr`. That first cycle is a read or a write according to R2 and R3.
- R6: The chip enables are sampled only on strobe cycles. A strobe cycle with any enable inactive (`ce_n` high, `ce2` low or `ce3_n` high) deselects the block. While deselected, the block makes no access and does not drive, until a strobe cycle finds all enables active. On cycles without a strobe, the enables have no effect.
- R7: While selected, a cycle with neither strobe and `adv_n` low moves to the next burst address. The upper address bits stay fixed. The low two bits are start XOR n when `seq_linear` is 0, and (start + n) mod 4 when `seq_linear` is 1, where n counts continue cycles modulo 4.
- R8: While selected, a cycle with neither strobe and `adv_n` high reuses the current burst address, for a read or for a write.
- R9: `dout_en` is high only when `oe_n` is low and the output register holds read data. It is low after write, deselect and sleeping cycles. `oe_n` acts on `dout_en` without waiting for a clock edge.
- R10: While `rst` is high and after its release, the block is deselected and `dout_en` is low.
- R11: Once `sleep` has been sampled high on two consecutive edges, commands are ignored and `dout_en` stays low. Normal operation returns after `sleep` has been sampled low on two consecutive edges. Array contents are kept throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data, four 8-bit lanes |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| wr_all_n | input | 1 | Global write, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Low-power retention request |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | Output drive enable |

## Verification
The array is first filled with global writes, some of them with byte strobes set that should have no effect. It is then read back with processor-strobe reads issued every cycle. This separates a wrong pipeline depth from a wrong write mask. All sixteen lane-strobe combinations are then applied to one word, which shows whether each lane is gated on its own and whether an all-high strobe set turns the cycle into a read. Bursts from every start address are run in both orders, along with suspend, masked-strobe, deselect, output-enable and sleep sequences. These show whether the address sequence, the strobe priority, the selection persistence and the blocking of accesses are each right.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Classification of one sampled clock cycle
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,  // deselected or ignored: no array access
    CYC_BEGIN = 2'd1,  // new burst at the external address
    CYC_NEXT  = 2'd2,  // step to the next burst address
    CYC_HOLD  = 2'd3   // reuse the current burst address
  } cyc_kind_e;

endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_use;
  logic [BURST_W-1:0] low_bits;

  always_comb begin
    cnt_use = step ? cnt_q + 1'b1 : cnt_q;
    if (linear) low_bits = base_q[BURST_W-1:0] + cnt_use;
    else        low_bits = base_q[BURST_W-1:0] ^ cnt_use;
    if (load) cur_addr = ext_addr;
    else      cur_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_use;
    end
  end

endmodule

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             proc_n,
  input  logic             ctrl_n,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             wr_all_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_kind_e        kind,
  output logic [LANES-1:0] lane_we,
  output logic             is_read,
  output logic             selected
);

  logic             proc_go;
  logic             strobe;
  logic             enables_ok;
  logic [LANES-1:0] wmask;
  logic             access;

  always_comb begin
    proc_go    = !proc_n && !ce_n;
    strobe     = proc_go || !ctrl_n;
    enables_ok = !ce_n && ce2 && !ce3_n;

    if (!wr_all_n)       wmask = '1;
    else if (!byte_wr_n) wmask = ~lane_wr_n;
    else                 wmask = '0;

    if (hold)          kind = CYC_NONE;
    else if (strobe)   kind = enables_ok ? CYC_BEGIN : CYC_NONE;
    else if (selected) kind = adv_n ? CYC_HOLD : CYC_NEXT;
    else               kind = CYC_NONE;

    access = (kind != CYC_NONE);
    if (access && !(kind == CYC_BEGIN && proc_go)) lane_we = wmask;
    else                                           lane_we = '0;
    is_read = access && (lane_we == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)                  selected <= 1'b0;
    else if (!hold && strobe) selected <= enables_ok;
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int BURST_W   = 2,
  parameter int SLEEP_DLY = 2,
  localparam int DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              oe_n,
  input  logic              seq_linear,
  input  logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  localparam int SC_W = (SLEEP_DLY > 1) ? $clog2(SLEEP_DLY) : 1;

  logic              asleep;
  logic [SC_W-1:0]   sleep_cnt;
  cyc_kind_e         kind;
  logic [LANES-1:0]  lane_we;
  logic              is_read;
  logic              selected;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rdata;
  logic              rd_v1;
  logic              rd_v2;
  logic [DATA_W-1:0] dout_q;

  // retention: state flips after SLEEP_DLY consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      asleep    <= 1'b0;
      sleep_cnt <= '0;
    end else if (sleep != asleep) begin
      if (sleep_cnt == SC_W'(SLEEP_DLY - 1)) begin
        asleep    <= sleep;
        sleep_cnt <= '0;
      end else begin
        sleep_cnt <= sleep_cnt + 1'b1;
      end
    end else begin
      sleep_cnt <= '0;
    end
  end

  sram_cycle_decode #(.LANES(LANES)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .hold      (asleep),
    .proc_n    (strobe_proc_n),
    .ctrl_n    (strobe_ctrl_n),
    .adv_n     (adv_n),
    .ce_n      (ce_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .wr_all_n  (wr_all_n),
    .byte_wr_n (byte_wr_n),
    .lane_wr_n (lane_wr_n),
    .kind      (kind),
    .lane_we   (lane_we),
    .is_read   (is_read),
    .selected  (selected)
  );

  burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (kind == CYC_BEGIN),
    .step     (kind == CYC_NEXT),
    .linear   (seq_linear),
    .ext_addr (addr),
    .cur_addr (cur_addr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk   (clk),
    .we    (lane_we),
    .addr  (cur_addr),
    .wdata (din),
    .rdata (rdata)
  );

  // second pipeline stage: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1 <= 1'b0;
      rd_v2 <= 1'b0;
    end else begin
      rd_v1 <= is_read;
      rd_v2 <= rd_v1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_v1) dout_q <= rdata;
  end

  assign dout    = dout_q;
  assign dout_en = rd_v2 && !oe_n && !asleep;

endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe_proc_n,
  input logic             strobe_ctrl_n,
  input logic             ce_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             wr_all_n,
  input logic             oe_n,
  input logic             dout_en,
  input logic             asleep,
  input logic             selected,
  input logic [1:0]       kind,
  input logic [LANES-1:0] lane_we
);

  logic proc_ok;
  logic any_strobe;
  logic proc_read_cmd;

  assign proc_ok       = !strobe_proc_n && !ce_n;
  assign any_strobe    = proc_ok || !strobe_ctrl_n;
  assign proc_read_cmd = proc_ok && ce2 && !ce3_n && !asleep && !rst;

  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dout_en);

  assert_proc_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(proc_read_cmd, 2) && !oe_n && !asleep) |-> dout_en);

  assert_global_write_lanes_R2: assert property (@(posedge clk) disable iff (rst)
    (kind != 2'd0 && !wr_all_n && !proc_ok) |-> (&lane_we));

  assert_disabled_strobe_deselects_R6: assert property (@(posedge clk) disable iff (rst)
    (!asleep && any_strobe && !ce2) |=> !selected);

  assert_select_held_without_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!asleep && !any_strobe) |=> $stable(selected));

  assert_sleep_blocks_writes_R11: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (lane_we == '0));

  assert_write_not_driven_R9: assert property (@(posedge clk) disable iff (rst)
    $past((|lane_we) && !rst, 2) |-> !dout_en);

endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .strobe_proc_n (strobe_proc_n),
  .strobe_ctrl_n (strobe_ctrl_n),
  .ce_n          (ce_n),
  .ce2           (ce2),
  .ce3_n         (ce3_n),
  .wr_all_n      (wr_all_n),
  .oe_n          (oe_n),
  .dout_en       (dout_en),
  .asleep        (asleep),
  .selected      (selected),
  .kind          (kind),
  .lane_we       (lane_we)
);

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;

  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [AW-1:0] addr;
  logic [31:0] din;
  logic        strobe_proc_n, strobe_ctrl_n, adv_n, ce_n, ce2, ce3_n;
  logic        wr_all_n, byte_wr_n, oe_n, seq_linear, sleep;
  logic [3:0]  lane_wr_n;
  logic [31:0] dout;
  logic        dout_en;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] mdl [16];

  always #4 clk = ~clk;

  burst_sram_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
    .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .oe_n(oe_n), .seq_linear(seq_linear), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; adv_n = 1'b1;
    ce_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    wr_all_n = 1'b1; byte_wr_n = 1'b1; lane_wr_n = 4'hF;
    oe_n = 1'b0; sleep = 1'b0; din = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101);
  endfunction

  function automatic logic [3:0] bo(input logic [3:0] st, input int n, input logic lin);
    logic [1:0] lo;
    lo = lin ? st[1:0] + 2'(n) : st[1:0] ^ 2'(n);
    return {st[3:2], lo};
  endfunction

  task automatic proc_read(input logic [3:0] a);
    idle; strobe_proc_n = 1'b0; addr = a;
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    idle; addr = '0; seq_linear = 1'b0; rst = 1'b1;
    repeat (3) tick;
    check("R10 in reset", 32'(dout_en), 32'd0);
    rst = 1'b0; tick;
    check("R10 after reset", 32'(dout_en), 32'd0);

    // fill with global writes; odd words also carry byte strobes
    for (int a = 0; a < 16; a++) begin
      idle; strobe_ctrl_n = 1'b0; addr = 4'(a); wr_all_n = 1'b0;
      if (a % 2 == 1) begin byte_wr_n = 1'b0; lane_wr_n = 4'b1010; end
      din = pat(a); mdl[a] = pat(a);
      tick;
    end
    idle; tick;
    check("R9 no drive after write", 32'(dout_en), 32'd0);

    // back-to-back processor reads; odd ones request a write (ignored, R4)
    for (int a = 0; a <= 16; a++) begin
      if (a < 16) begin
        proc_read(4'(a));
        if (a % 2 == 1) begin wr_all_n = 1'b0; din = 32'hDEAD_BEEF; end
      end else idle;
      tick;
      if (a > 0) begin
        check("R1 drive", 32'(dout_en), 32'd1);
        check("R2 R4 R5 R1 readback", dout, mdl[a-1]);
      end
    end

    // all lane strobe combinations on word 3
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d;
      d = 32'h8040_2010 + 32'(m) * 32'h0101_0101;
      idle; strobe_ctrl_n = 1'b0; addr = 4'd3; byte_wr_n = 1'b0;
      lane_wr_n = ~4'(m); din = d;
      for (int i = 0; i < 4; i++) if (m[i]) mdl[3][8*i +: 8] = d[8*i +: 8];
      tick;
      idle; tick;
      check("R3 read when no lane", 32'(dout_en), 32'(m == 0));
      proc_read(4'd3); tick;
      idle; tick;
      check("R3 lane mask", dout, mdl[3]);
    end

    // bursts from every start, both orders
    for (int lin = 0; lin < 2; lin++) begin
      seq_linear = 1'(lin);
      for (int st = 0; st < 16; st++) begin
        proc_read(4'(st)); tick;
        for (int n = 1; n <= 4; n++) begin
          idle; adv_n = (n <= 3) ? 1'b0 : 1'b1;
          tick;
          check("R7 burst order", dout, mdl[bo(4'(st), n - 1, 1'(lin))]);
        end
      end
    end

    // suspend reads and writes (linear order)
    seq_linear = 1'b1;
    proc_read(4'd9); tick;
    idle; tick; check("R8 suspend read", dout, mdl[9]);
    idle; tick; check("R8 suspend read", dout, mdl[9]);
    idle; adv_n = 1'b0; tick; check("R8 suspend read", dout, mdl[9]);
    idle; tick; check("R7 after suspend", dout, mdl[10]);
    idle; strobe_ctrl_n = 1'b0; addr = 4'd12; wr_all_n = 1'b0; din = 32'hAAAA_0001; tick;
    idle; wr_all_n = 1'b0; din = 32'hBBBB_0002; tick;
    idle; adv_n = 1'b0; wr_all_n = 1'b0; din = 32'hCCCC_0003; tick;
    mdl[12] = 32'hBBBB_0002; mdl[13] = 32'hCCCC_0003;
    proc_read(4'd12); tick;
    proc_read(4'd13); tick; check("R8 suspend write", dout, mdl[12]);
    idle; tick; check("R7 R5 burst write", dout, mdl[13]);

    // processor strobe masked by inactive primary enable
    proc_read(4'd2); tick;
    idle; strobe_proc_n = 1'b0; ce_n = 1'b1; addr = 4'd7; tick;
    idle; tick;
    check("R4 masked strobe", dout, mdl[2]);
    check("R4 masked stays selected", 32'(dout_en), 32'd1);

    // enables ignored without strobe, then deselect
    proc_read(4'd4); tick;
    idle; ce_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; tick;
    idle; tick;
    check("R6 enables ignored", dout, mdl[4]);
    check("R6 enables ignored drive", 32'(dout_en), 32'd1);
    idle; strobe_ctrl_n = 1'b0; ce2 = 1'b0; tick;
    idle; adv_n = 1'b0; wr_all_n = 1'b0; din = 32'h0BAD_0BAD; tick;
    idle; tick;
    check("R6 deselected no drive", 32'(dout_en), 32'd0);
    proc_read(4'd5); tick;
    idle; tick;
    check("R6 no write while deselected", dout, mdl[5]);
    idle; strobe_proc_n = 1'b0; ce3_n = 1'b1; tick;
    idle; tick; idle; tick;
    check("R6 deselect by third enable", 32'(dout_en), 32'd0);

    // output enable
    proc_read(4'd1); tick;
    idle; oe_n = 1'b1; tick;
    check("R9 oe high", 32'(dout_en), 32'd0);
    oe_n = 1'b0; #1;
    check("R9 oe low", 32'(dout_en), 32'd1);
    check("R9 oe data", dout, mdl[1]);

    // sleep
    idle; sleep = 1'b1; tick; tick;
    idle; sleep = 1'b1; strobe_ctrl_n = 1'b0; addr = 4'd0; wr_all_n = 1'b0; din = 32'hFFFF_0000; tick;
    idle; sleep = 1'b1; strobe_proc_n = 1'b0; addr = 4'd0; tick;
    idle; sleep = 1'b1; tick;
    check("R11 asleep no drive", 32'(dout_en), 32'd0);
    idle; tick; tick;
    proc_read(4'd0); tick;
    idle; tick;
    check("R11 wake drive", 32'(dout_en), 32'd1);
    check("R11 contents kept", dout, mdl[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule